// File: doc/BRIEF.md
# 32-bit Down-Counting Interval Timer

The block is a general-purpose interval timer for one 32-bit countdown. Two 16-bit load halves form a single 32-bit reload value, and the counter counts down from it one step per clock. When the count reaches zero the block flags a sticky timeout, can raise an interrupt, and can emit a one-cycle trigger pulse that starts other logic. The reload value is copied back into the counter on the cycle after the zero. A per-timer mode field selects one of two behaviours. In one-shot mode the timer stops and drops its own enable. In periodic mode it keeps running.

Software uses a single-cycle register port. The port has a write strobe, a word address, write data and combinational read data. Through it software sets the configuration, the mode fields, control, the load value and the interrupt mask, and it reads the count and the status. A stall control bit freezes the count. A nonzero configuration value selects the calendar-clock arrangement. Counting for that arrangement is not part of this block, so the countdown stays idle while it is selected.

The sequencing core is a two-state machine. IDLE holds the count. RUN decrements it. The IDLE-to-RUN transition ("start") is taken when the enable bit is set and the configuration is 0. The RUN-to-IDLE transition is taken in two cases. "Halt" happens when software clears the enable bit or changes the configuration. "Expire" happens when the count is zero in one-shot mode. The RUN-to-RUN transition at zero in periodic mode is "wrap".

Top module: `gp_timer32`

## Requirements
- R1: After reset every register reads zero (word offsets 0 to 9), and the interrupt and trigger outputs are low.
- R2: A write to LOAD (offset 4) stores bits [31:16] in the upper load half and bits [15:0] in the lower half, and LOAD reads back as {upper, lower}. The count, read at COUNT (offset 5), takes the written value at the same clock edge, and this holds whether or not the timer is running.
- R3: Writing CTL (offset 3) with bit 0 (enable) set starts the machine on the next edge. From then on the count drops by one per cycle, so the count is zero in the (N+1)-th cycle after the start cycle for load value N.
- R4: The load value is copied into the count at the edge that ends a zero cycle. In one-shot mode this edge also clears CTL bit 0, the machine goes to IDLE, and COUNT keeps the load value.
- R5: In periodic mode the timer keeps running after zero, and successive zero cycles are N+1 cycles apart.
- R6: The AMODE field (offset 1, bits [1:0]) alone picks the mode: value 2 is periodic and any other value is one-shot. BMODE (offset 2) is stored but has no effect.
- R7: A zero cycle sets the raw timeout bit (RAW, offset 7, bit 0). The bit stays set until a 1 is written to bit 0 of CLEAR (offset 9). Writing 0 there does nothing, and a zero cycle at the same edge as a clear leaves the bit set.
- R8: MASKED (offset 8, bit 0) and the interrupt output equal the RAW bit ANDed with MASK (offset 6) bit 0.
- R9: With CTL bit 2 set, the trigger output is high exactly in zero cycles. With it clear, the trigger output stays low while timeouts still set RAW.
- R10: While CTL bit 1 (stall) is set, the count holds its value.
- R11: While CFG (offset 0, bits [2:0]) is nonzero the count does not move. After CFG returns to 0, counting resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | 2*HALF_W | Write data |
| bus_rdata | output | 2*HALF_W | Read data for bus_addr, combinational |
| tmr_irq | output | 1 | Masked timeout interrupt |
| tmr_trig | output | 1 | One-cycle pulse in a zero cycle when triggering is enabled |

## Verification
The hardest case to reach is a zero cycle that meets a clear write at the same edge, because the clear must land exactly on the edge that ends the zero cycle. The bench runs a periodic timer with triggering enabled and waits for the trigger pulse. At that falling edge it starts the clear write, so the write's edge is the one that ends the zero cycle, and RAW must still read 1 afterwards. Load rewrites during counting and stall toggles are timed the same way, counting falling edges from the start of the write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register word offsets on the bus
    localparam int OFS_CFG    = 0;
    localparam int OFS_AMODE  = 1;
    localparam int OFS_BMODE  = 2;
    localparam int OFS_CTL    = 3;
    localparam int OFS_LOAD   = 4;
    localparam int OFS_COUNT  = 5;
    localparam int OFS_MASK   = 6;
    localparam int OFS_RAW    = 7;
    localparam int OFS_MASKED = 8;
    localparam int OFS_CLEAR  = 9;

    // Control bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_STALL = 1;
    localparam int CTL_TRGEN = 2;

    // AMODE value selecting periodic operation
    localparam logic [1:0] MODE_PERIODIC = 2'd2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 4,
    localparam int DW = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     cnt,
    input  logic              hit,
    input  logic              clr_en,
    output logic              cfg_timer,
    output logic              periodic,
    output logic              en,
    output logic              stall,
    output logic              trgen,
    output logic              load_wr,
    output logic [DW-1:0]     load_val,
    output logic              raw,
    output logic              irq,
    output logic [DW-1:0]     rdata
);

    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_AMODE  = ADDR_W'(OFS_AMODE);
    localparam logic [ADDR_W-1:0] A_BMODE  = ADDR_W'(OFS_BMODE);
    localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);

    logic [2:0]        cfg_q;
    logic [1:0]        amode_q;
    logic [1:0]        bmode_q;
    logic [2:0]        ctl_q;
    logic              mask_q;
    logic              raw_q;
    logic [HALF_W-1:0] half_q [2];

    logic wr_cfg, wr_amode, wr_bmode, wr_ctl, wr_mask, wr_clear;

    assign wr_cfg   = we && (addr == A_CFG);
    assign wr_amode = we && (addr == A_AMODE);
    assign wr_bmode = we && (addr == A_BMODE);
    assign wr_ctl   = we && (addr == A_CTL);
    assign wr_mask  = we && (addr == A_MASK);
    assign wr_clear = we && (addr == A_CLEAR);
    assign load_wr  = we && (addr == A_LOAD);

    // Each load half captures its own slice of a 32-bit load write
    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q[h] <= '0;
            end else if (load_wr) begin
                half_q[h] <= wdata[h*HALF_W +: HALF_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            amode_q <= '0;
            bmode_q <= '0;
            ctl_q   <= '0;
            mask_q  <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            if (wr_cfg)   cfg_q   <= wdata[2:0];
            if (wr_amode) amode_q <= wdata[1:0];
            if (wr_bmode) bmode_q <= wdata[1:0];
            if (wr_mask)  mask_q  <= wdata[0];
            if (wr_ctl)   ctl_q   <= wdata[2:0];
            if (clr_en)   ctl_q[CTL_EN] <= 1'b0;
            // A timeout at the same edge as a clear keeps the bit set
            if (hit) begin
                raw_q <= 1'b1;
            end else if (wr_clear && wdata[0]) begin
                raw_q <= 1'b0;
            end
        end
    end

    assign load_val  = {half_q[1], half_q[0]};
    assign cfg_timer = (cfg_q == 3'd0);
    assign periodic  = (amode_q == MODE_PERIODIC);
    assign en        = ctl_q[CTL_EN];
    assign stall     = ctl_q[CTL_STALL];
    assign trgen     = ctl_q[CTL_TRGEN];
    assign raw       = raw_q;
    assign irq       = raw_q & mask_q;

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CFG:    rdata[2:0] = cfg_q;
            A_AMODE:  rdata[1:0] = amode_q;
            A_BMODE:  rdata[1:0] = bmode_q;
            A_CTL:    rdata[2:0] = ctl_q;
            A_LOAD:   rdata      = load_val;
            A_COUNT:  rdata      = cnt;
            A_MASK:   rdata[0]   = mask_q;
            A_RAW:    rdata[0]   = raw_q;
            A_MASKED: rdata[0]   = raw_q & mask_q;
            default:  rdata      = '0;
        endcase
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_ok,
    input  logic          stall,
    input  logic          periodic,
    input  logic          load_wr,
    input  logic [CW-1:0] load_data,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          hit,
    output logic          clr_en
);

    tmr_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          at_zero;
    logic          step;

    assign at_zero = (cnt_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, halt, expire, wrap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_ok) state_d = ST_RUN;
            ST_RUN: begin
                if (!run_ok) begin
                    state_d = ST_IDLE;
                end else if (!stall && at_zero && !periodic) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        hit    = 1'b0;
        clr_en = 1'b0;
        step   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                if (run_ok && !stall) begin
                    hit    = at_zero;
                    step   = !at_zero;
                    clr_en = at_zero && !periodic;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_wr) begin
            cnt_q <= load_data;
        end else if (hit) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/gp_timer32.sv
module gp_timer32
    import tmr_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 4,
    localparam int DW = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              tmr_irq,
    output logic              tmr_trig
);

    logic [DW-1:0] cnt_w;
    logic [DW-1:0] load_val_w;
    logic          hit_w, clr_en_w;
    logic          cfg_timer_w, periodic_w, en_w, stall_w, trgen_w;
    logic          load_wr_w, raw_w;

    tmr_regs #(
        .HALF_W (HALF_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cnt       (cnt_w),
        .hit       (hit_w),
        .clr_en    (clr_en_w),
        .cfg_timer (cfg_timer_w),
        .periodic  (periodic_w),
        .en        (en_w),
        .stall     (stall_w),
        .trgen     (trgen_w),
        .load_wr   (load_wr_w),
        .load_val  (load_val_w),
        .raw       (raw_w),
        .irq       (tmr_irq),
        .rdata     (bus_rdata)
    );

    tmr_core #(
        .CW (DW)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_ok    (en_w && cfg_timer_w),
        .stall     (stall_w),
        .periodic  (periodic_w),
        .load_wr   (load_wr_w),
        .load_data (bus_wdata),
        .load_val  (load_val_w),
        .cnt       (cnt_w),
        .hit       (hit_w),
        .clr_en    (clr_en_w)
    );

    assign tmr_trig = hit_w & trgen_w;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [DW-1:0]     cnt,
    input logic [DW-1:0]     load_val,
    input logic              hit,
    input logic              periodic,
    input logic              en,
    input logic              stall,
    input logic              raw,
    input logic              irq,
    input logic              trig
);

    logic wr_load, wr_ctl, wr_clr1;
    assign wr_load = we && (addr == ADDR_W'(OFS_LOAD));
    assign wr_ctl  = we && (addr == ADDR_W'(OFS_CTL));
    assign wr_clr1 = we && (addr == ADDR_W'(OFS_CLEAR)) && wdata[0];

    // R9
    trig_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (cnt == '0));

    // R7
    raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !wr_clr1) |=> raw);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raw);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !wr_load) |=> $stable(cnt));

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_load) |=> (cnt == $past(load_val)));

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !periodic && !wr_ctl) |=> !en);

    // R8
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw);

endmodule

bind gp_timer32 tmr_chk #(
    .ADDR_W (ADDR_W),
    .DW     (DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cnt      (cnt_w),
    .load_val (load_val_w),
    .hit      (hit_w),
    .periodic (periodic_w),
    .en       (en_w),
    .stall    (stall_w),
    .raw      (raw_w),
    .irq      (tmr_irq),
    .trig     (tmr_trig)
);

// File: tb/sim_gp_timer32.sv
module sim_gp_timer32;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 32;

    localparam logic [AW-1:0] R_CFG = 4'd0, R_AMODE = 4'd1, R_BMODE = 4'd2,
        R_CTL = 4'd3, R_LOAD = 4'd4, R_COUNT = 4'd5, R_MASK = 4'd6,
        R_RAW = 4'd7, R_MASKED = 4'd8, R_CLEAR = 4'd9;

    // {periodic, load value}
    localparam logic [32:0] VEC [6] = '{
        {1'b0, 32'd3},
        {1'b1, 32'd3},
        {1'b0, 32'd0},
        {1'b1, 32'd0},
        {1'b1, 32'd7},
        {1'b0, 32'h0001_0002}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          tmr_irq, tmr_trig;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gp_timer32 u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_irq   (tmr_irq),
        .tmr_trig  (tmr_trig)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts at a falling edge, returns at the falling edge after the write edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_trig(input int limit, output int k);
        k = 0;
        while (!tmr_trig && k <= limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v, v2;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 10; a++) begin
            rd(AW'(a), v);
            chk(v == 0, "R1 reset read", v, 0);
        end
        chk(!tmr_irq && !tmr_trig, "R1 outputs low", {tmr_irq, tmr_trig}, 0);

        // Table-driven runs: R3, R4, R5, R7, R8, R9
        for (int i = 0; i < 6; i++) begin
            bit per;
            logic [31:0] n;
            per = VEC[i][32];
            n = VEC[i][31:0];
            wr(R_MASK, 1);
            wr(R_AMODE, per ? 32'd2 : 32'd1);
            wr(R_LOAD, n);
            wr(R_CTL, 32'h5);
            wait_trig(int'(n) + 10, k);
            chk(k == int'(n) + 1, "R3 cycles to zero", k, n + 1);
            if (per) begin
                @(negedge clk);
                wait_trig(int'(n) + 10, k);
                chk(k == int'(n), "R5 period spacing", k + 1, n + 1);
                chk(tmr_irq, "R8 irq with mask", tmr_irq, 1);
                wr(R_CTL, 0);
            end else begin
                @(negedge clk);
                if (n != 0) chk(!tmr_trig, "R9 one-cycle trigger", tmr_trig, 0);
                rd(R_CTL, v);
                chk(v == 32'h4, "R4 enable cleared", v, 4);
                rd(R_COUNT, v);
                chk(v == n, "R4 count reloaded", v, n);
                rd(R_RAW, v);
                chk(v == 1, "R7 raw set", v, 1);
                chk(tmr_irq, "R8 irq with mask", tmr_irq, 1);
            end
            wr(R_CLEAR, 1);
            rd(R_RAW, v);
            chk(v == 0, "R7 clear", v, 0);
        end

        // R2: halves and immediate count load
        wr(R_LOAD, 32'hABCD_1234);
        rd(R_LOAD, v);
        chk(v == 32'hABCD_1234, "R2 load readback", v, 32'hABCD_1234);
        rd(R_COUNT, v);
        chk(v == 32'hABCD_1234, "R2 count takes load", v, 32'hABCD_1234);

        // R3 and R2: reload while running
        wr(R_AMODE, 2);
        wr(R_LOAD, 100);
        wr(R_CTL, 1);
        repeat (5) @(negedge clk);
        rd(R_COUNT, v);
        chk(v == 96, "R3 decrement rate", v, 96);
        wr(R_LOAD, 20);
        rd(R_COUNT, v);
        chk(v == 20, "R2 load while running", v, 20);
        @(negedge clk);
        rd(R_COUNT, v);
        chk(v == 19, "R2 continues from new load", v, 19);

        // R10: stall
        wr(R_CTL, 3);
        rd(R_COUNT, v);
        repeat (4) @(negedge clk);
        rd(R_COUNT, v2);
        chk(v2 == v, "R10 stall holds", v2, v);
        wr(R_CTL, 1);
        rd(R_COUNT, v2);
        chk(v2 == v, "R10 hold through release edge", v2, v);
        @(negedge clk);
        rd(R_COUNT, v2);
        chk(v2 == v - 1, "R10 resume", v2, v - 1);

        // R9: no trigger when disabled, raw still set
        wr(R_CLEAR, 1);
        wr(R_LOAD, 2);
        wait_trig(8, k);
        chk(k > 8, "R9 no trigger when off", k, 9);
        rd(R_RAW, v);
        chk(v == 1, "R9 raw without trigger", v, 1);

        // R8: mask
        wr(R_MASK, 0);
        rd(R_MASKED, v);
        chk(v == 0 && !tmr_irq, "R8 masked off", {v[0], tmr_irq}, 0);
        wr(R_MASK, 1);
        rd(R_MASKED, v);
        chk(v == 1 && tmr_irq, "R8 masked on", {v[0], tmr_irq}, 3);

        // R7: writing 0 to clear has no effect
        wr(R_CTL, 0);
        wr(R_CLEAR, 0);
        rd(R_RAW, v);
        chk(v == 1, "R7 clear with zero ignored", v, 1);

        // R7: set wins over a clear at the same edge
        wr(R_CLEAR, 1);
        wr(R_LOAD, 4);
        wr(R_CTL, 5);
        wait_trig(10, k);
        wr(R_CLEAR, 1);
        rd(R_RAW, v);
        chk(v == 1, "R7 set wins over clear", v, 1);
        wr(R_CTL, 0);
        wr(R_CLEAR, 1);

        // R6: BMODE ignored, AMODE one-shot governs
        wr(R_AMODE, 1);
        wr(R_BMODE, 2);
        wr(R_LOAD, 2);
        wr(R_CTL, 5);
        wait_trig(10, k);
        chk(k == 3, "R6 one-shot timing", k, 3);
        repeat (6) @(negedge clk);
        rd(R_COUNT, v);
        chk(v == 2, "R6 stopped despite BMODE", v, 2);
        rd(R_CTL, v);
        chk(v == 4, "R6 enable cleared", v, 4);

        // R11: nonzero configuration holds the count
        wr(R_CLEAR, 1);
        wr(R_CFG, 1);
        wr(R_LOAD, 5);
        wr(R_CTL, 1);
        repeat (10) @(negedge clk);
        rd(R_COUNT, v);
        chk(v == 5, "R11 no counting in cfg 1", v, 5);
        rd(R_RAW, v);
        chk(v == 0, "R11 no timeout in cfg 1", v, 0);
        wr(R_CFG, 0);
        repeat (3) @(negedge clk);
        rd(R_COUNT, v);
        chk(v == 3, "R11 resumes in cfg 0", v, 3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule